// File: doc/BRIEF.md
# Multi-Stack Buffer Descriptor Manager

This block keeps a set of independent last-in first-out stacks of free buffer addresses behind a memory-mapped load/store port. A store into a stack's window pushes the buffer address carried in the write data onto that stack. A load from the same window pops the most recently pushed address and returns it as a 64-bit descriptor. The descriptor also carries status: which stack answered, a flag marking the buffer as hardware-managed, the stack's encoded buffer size, and a two-bit outcome code.

The target stack comes from address bits, not from the write data. An access is claimed only when a three-bit region field in the address matches this unit's region number. A pop from an empty stack never stalls. It answers at once with a distinct failure code. Software writes each stack's size code through a small side port at configuration time. A push to a full stack is discarded, and a sticky per-stack overflow flag records it.

Top module: `buf_stack_mgr`

## Requirements
- R1: An access is claimed only when req_addr[28:26] equals 6. A request with any other region value changes no stack and gives no response.
- R2: req_addr[7:3] selects the stack. The popped descriptor reports that index in rsp_data[52:48].
- R3: A claimed store pushes req_wdata[41:7] onto the selected stack. Pops return the pushed addresses in reverse order of pushing, and each stack is independent of the others.
- R4: A claimed load raises rsp_valid for exactly one cycle, in the cycle after the request, with the descriptor on rsp_data. Stores and unclaimed requests never raise rsp_valid.
- R5: The outcome code in rsp_data[63:62] is 0 when an entry was popped. It is 3 when the stack was empty, and in that case the address field rsp_data[41:7] reads zero.
- R6: The hardware-managed flag rsp_data[58] always reads 1 in a response.
- R7: On a push, every write-data bit outside [41:7] is ignored. The stack index, size, flag and code fields of a descriptor come only from the design, and rsp_data[6:0], [47:42] and [57:53] read zero.
- R8: rsp_data[61:59] holds the three-bit size code last written for that stack through cfg_we/cfg_stack/cfg_size, and it is 0 after reset.
- R9: A push to a stack that already holds DEPTH entries is dropped, and the stack's contents stay intact. The push sets bit ovf_flags[stack], and that bit stays set until reset.
- R10: After reset every stack is empty, ovf_flags is zero and rsp_valid is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Access request strobe |
| req_write | input | 1 | 1 = store (push), 0 = load (pop) |
| req_addr | input | 32 | Access address: region at [28:26], stack at [7:3] |
| req_wdata | input | 64 | Store data; buffer address in [41:7] |
| cfg_we | input | 1 | Size-code write strobe |
| cfg_stack | input | 5 | Stack whose size code is written |
| cfg_size | input | 3 | Size code value |
| rsp_valid | output | 1 | Pop response strobe |
| rsp_data | output | 64 | Popped descriptor |
| ovf_flags | output | NUM_STACKS | Sticky per-stack overflow flags |

## Verification
The hardest state to reach from the ports is a completely full stack that keeps taking pushes. Purely random traffic spread across 32 stacks almost never piles up DEPTH entries on one of them. A directed sequence therefore fills one stack past its depth and then drains it, which checks that the overflowing push left the top entry unchanged. The random phase draws from only five stacks and weights pushes above pops, so several stacks cross both the full and the empty boundary many times. Every response is compared against a bench-side model of the stacks.

// File: rtl/bsm_pkg.sv
package bsm_pkg;
  localparam int ADDR_W   = 32;
  localparam int DATA_W   = 64;
  localparam int SEL_LO   = 3;
  localparam int SEL_W    = 5;
  localparam int REG_LO   = 26;
  localparam int REG_W    = 3;
  localparam logic [REG_W-1:0] REG_MINE = 3'd6;
  localparam int BA_LO    = 7;
  localparam int BA_W     = 35;
  localparam int SZ_W     = 3;

  typedef enum logic [1:0] {
    CODE_OK    = 2'd0,
    CODE_EMPTY = 2'd3
  } pop_code_e;

  typedef struct packed {
    logic             hit;
    logic             is_push;
    logic [SEL_W-1:0] sel;
  } bsm_cmd_t;

  typedef struct packed {
    logic [1:0]       code;
    logic [SZ_W-1:0]  size;
    logic             hw;
    logic [4:0]       rsv_a;
    logic [SEL_W-1:0] sidx;
    logic [5:0]       rsv_b;
    logic [BA_W-1:0]  baddr;
    logic [6:0]       rsv_c;
  } desc_t;
endpackage

// File: rtl/bsm_decode.sv
module bsm_decode
  import bsm_pkg::*;
(
  input  logic             req_valid,
  input  logic             req_write,
  input  logic [REG_W-1:0] req_region,
  input  logic [SEL_W-1:0] req_sel,
  output bsm_cmd_t         cmd
);
  always_comb begin
    cmd.hit     = req_valid && (req_region == REG_MINE);
    cmd.is_push = req_write;
    cmd.sel     = req_sel;
  end
endmodule

// File: rtl/bsm_stack_bank.sv
module bsm_stack_bank
  import bsm_pkg::*;
#(
  parameter int NUM_STACKS = 32,
  parameter int DEPTH      = 16
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  bsm_cmd_t              cmd,
  input  logic [BA_W-1:0]       push_addr,
  output logic [BA_W-1:0]       top_addr,
  output logic                  top_avail,
  output logic [NUM_STACKS-1:0] ovf_flags
);
  localparam int CNT_W = $clog2(DEPTH + 1);
  localparam int PTR_W = $clog2(DEPTH);

  logic [BA_W-1:0]       top_arr [NUM_STACKS];
  logic [NUM_STACKS-1:0] nonempty;

  for (genvar g = 0; g < NUM_STACKS; g++) begin : g_stk
    logic [CNT_W-1:0] cnt_q, cnt_d;
    logic             ovf_q, ovf_d;
    logic [BA_W-1:0]  mem_q [DEPTH];
    logic             sel, full, wr_en;

    assign sel   = cmd.hit && (cmd.sel == SEL_W'(g));
    assign full  = (cnt_q == CNT_W'(DEPTH));
    assign wr_en = sel && cmd.is_push && !full;

    always_comb begin
      cnt_d = cnt_q;
      ovf_d = ovf_q;
      if (sel && cmd.is_push) begin
        if (full) ovf_d = 1'b1;
        else      cnt_d = cnt_q + CNT_W'(1);
      end else if (sel && !cmd.is_push && (cnt_q != '0)) begin
        cnt_d = cnt_q - CNT_W'(1);
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        cnt_q <= '0;
        ovf_q <= 1'b0;
      end else begin
        cnt_q <= cnt_d;
        ovf_q <= ovf_d;
      end
    end

    always_ff @(posedge clk) begin
      if (wr_en) mem_q[cnt_q[PTR_W-1:0]] <= push_addr;
    end

    assign nonempty[g]  = (cnt_q != '0);
    assign top_arr[g]   = mem_q[PTR_W'(cnt_q - CNT_W'(1))];
    assign ovf_flags[g] = ovf_q;
  end

  always_comb begin
    top_addr  = '0;
    top_avail = 1'b0;
    for (int i = 0; i < NUM_STACKS; i++) begin
      if (cmd.sel == SEL_W'(i)) begin
        top_addr  = top_arr[i];
        top_avail = nonempty[i];
      end
    end
  end
endmodule

// File: rtl/bsm_size_cfg.sv
module bsm_size_cfg
  import bsm_pkg::*;
#(
  parameter int NUM_STACKS = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_we,
  input  logic [SEL_W-1:0] cfg_stack,
  input  logic [SZ_W-1:0]  cfg_size,
  input  logic [SEL_W-1:0] rd_sel,
  output logic [SZ_W-1:0]  rd_size
);
  logic [SZ_W-1:0] size_q [NUM_STACKS];

  for (genvar g = 0; g < NUM_STACKS; g++) begin : g_sz
    logic en;
    assign en = cfg_we && (cfg_stack == SEL_W'(g));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  size_q[g] <= '0;
      else if (en) size_q[g] <= cfg_size;
    end
  end

  always_comb begin
    rd_size = '0;
    for (int i = 0; i < NUM_STACKS; i++) begin
      if (rd_sel == SEL_W'(i)) rd_size = size_q[i];
    end
  end
endmodule

// File: rtl/bsm_resp.sv
module bsm_resp
  import bsm_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  bsm_cmd_t          cmd,
  input  logic [BA_W-1:0]   top_addr,
  input  logic              top_avail,
  input  logic [SZ_W-1:0]   size_code,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_data
);
  desc_t desc_d, desc_q;
  logic  pop_req;
  logic  vld_q;

  assign pop_req = cmd.hit && !cmd.is_push;

  always_comb begin
    desc_d       = '0;
    desc_d.code  = top_avail ? CODE_OK : CODE_EMPTY;
    desc_d.size  = size_code;
    desc_d.hw    = 1'b1;
    desc_d.sidx  = cmd.sel;
    if (top_avail) desc_d.baddr = top_addr;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q  <= 1'b0;
      desc_q <= '0;
    end else begin
      vld_q <= pop_req;
      if (pop_req) desc_q <= desc_d;
    end
  end

  assign rsp_valid = vld_q;
  assign rsp_data  = desc_q;
endmodule

// File: rtl/buf_stack_mgr.sv
module buf_stack_mgr
  import bsm_pkg::*;
#(
  parameter int NUM_STACKS = 32,
  parameter int DEPTH      = 16
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  req_valid,
  input  logic                  req_write,
  input  logic [31:0]           req_addr,
  input  logic [63:0]           req_wdata,
  input  logic                  cfg_we,
  input  logic [4:0]            cfg_stack,
  input  logic [2:0]            cfg_size,
  output logic                  rsp_valid,
  output logic [63:0]           rsp_data,
  output logic [NUM_STACKS-1:0] ovf_flags
);
  bsm_cmd_t        cmd;
  logic [BA_W-1:0] top_addr;
  logic            top_avail;
  logic [SZ_W-1:0] size_code;
  logic            unused_ok;

  assign unused_ok = ^{req_addr[31:29], req_addr[25:8], req_addr[2:0],
                       req_wdata[63:42], req_wdata[6:0]};

  bsm_decode u_dec (
    .req_valid  (req_valid),
    .req_write  (req_write),
    .req_region (req_addr[REG_LO +: REG_W]),
    .req_sel    (req_addr[SEL_LO +: SEL_W]),
    .cmd        (cmd)
  );

  bsm_stack_bank #(.NUM_STACKS(NUM_STACKS), .DEPTH(DEPTH)) u_bank (
    .clk       (clk),
    .rst_n     (rst_n),
    .cmd       (cmd),
    .push_addr (req_wdata[BA_LO +: BA_W]),
    .top_addr  (top_addr),
    .top_avail (top_avail),
    .ovf_flags (ovf_flags)
  );

  bsm_size_cfg #(.NUM_STACKS(NUM_STACKS)) u_cfg (
    .clk       (clk),
    .rst_n     (rst_n),
    .cfg_we    (cfg_we),
    .cfg_stack (cfg_stack),
    .cfg_size  (cfg_size),
    .rd_sel    (cmd.sel),
    .rd_size   (size_code)
  );

  bsm_resp u_rsp (
    .clk       (clk),
    .rst_n     (rst_n),
    .cmd       (cmd),
    .top_addr  (top_addr),
    .top_avail (top_avail),
    .size_code (size_code),
    .rsp_valid (rsp_valid),
    .rsp_data  (rsp_data)
  );
endmodule

// File: rtl/bsm_checker.sv
module bsm_checker
  import bsm_pkg::*;
#(
  parameter int NUM_STACKS = 32
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  req_valid,
  input logic                  req_write,
  input logic [31:0]           req_addr,
  input logic                  rsp_valid,
  input logic [63:0]           rsp_data,
  input logic [NUM_STACKS-1:0] ovf_flags
);
  logic rd_hit;
  logic unused_ok;
  assign rd_hit = req_valid && !req_write && (req_addr[REG_LO +: REG_W] == REG_MINE);
  assign unused_ok = ^{req_addr[31:29], req_addr[25:8], req_addr[2:0]};

  assert_rsp_after_pop_R4: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> $past(rd_hit));

  assert_pop_gets_rsp_R4: assert property (@(posedge clk) disable iff (!rst_n)
    rd_hit |=> rsp_valid);

  assert_sidx_echo_R2: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> (rsp_data[52:48] == $past(req_addr[SEL_LO +: SEL_W])));

  assert_hw_flag_R6: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> rsp_data[58]);

  assert_code_legal_R5: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> ((rsp_data[63:62] == 2'd0) || (rsp_data[63:62] == 2'd3)));

  assert_empty_zero_addr_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_data[63:62] == 2'd3) |-> (rsp_data[41:7] == '0));

  assert_ovf_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (($past(ovf_flags) & ~ovf_flags) == '0));
endmodule

bind buf_stack_mgr bsm_checker #(.NUM_STACKS(NUM_STACKS)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .req_valid (req_valid),
  .req_write (req_write),
  .req_addr  (req_addr),
  .rsp_valid (rsp_valid),
  .rsp_data  (rsp_data),
  .ovf_flags (ovf_flags)
);

// File: tb/buf_stack_mgr_test.sv
module buf_stack_mgr_test;
  localparam int CLK_PERIOD = 10;
  localparam int NS = 32;
  localparam int DP = 16;

  logic        clk, rst_n;
  logic        req_valid, req_write;
  logic [31:0] req_addr;
  logic [63:0] req_wdata;
  logic        cfg_we;
  logic [4:0]  cfg_stack;
  logic [2:0]  cfg_size;
  logic        rsp_valid;
  logic [63:0] rsp_data;
  logic [NS-1:0] ovf_flags;

  int tests_run = 0;
  int tests_failed = 0;

  logic [34:0] mdl [NS][DP];
  int          mcnt [NS];
  logic [2:0]  msize [NS];
  logic [NS-1:0] movf;

  buf_stack_mgr #(.NUM_STACKS(NS), .DEPTH(DP)) uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .cfg_we(cfg_we),
    .cfg_stack(cfg_stack), .cfg_size(cfg_size), .rsp_valid(rsp_valid),
    .rsp_data(rsp_data), .ovf_flags(ovf_flags)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
    tests_run++;
    if (act !== exp) begin
      tests_failed++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] mk_addr(logic [2:0] region, int s);
    logic [31:0] a;
    a = $urandom;
    a[28:26] = region;
    a[7:3] = s[4:0];
    return a;
  endfunction

  function automatic logic [63:0] exp_desc(int s, logic ok, logic [34:0] a);
    logic [63:0] d;
    d = '0;
    d[63:62] = ok ? 2'd0 : 2'd3;
    d[61:59] = msize[s];
    d[58] = 1'b1;
    d[52:48] = s[4:0];
    if (ok) d[41:7] = a;
    return d;
  endfunction

  // all tasks start and end at a falling edge
  task automatic do_push(int s, logic [63:0] wd, string tag);
    req_valid = 1'b1; req_write = 1'b1; req_addr = mk_addr(3'd6, s); req_wdata = wd;
    if (mcnt[s] < DP) begin mdl[s][mcnt[s]] = wd[41:7]; mcnt[s]++; end
    else movf[s] = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    chk({tag, " R4 no rsp on push"}, {63'd0, rsp_valid}, 64'd0);
    chk({tag, " R9 ovf flags"}, 64'(ovf_flags), 64'(movf));
  endtask

  task automatic do_pop(int s, string tag);
    logic [63:0] e;
    req_valid = 1'b1; req_write = 1'b0; req_addr = mk_addr(3'd6, s); req_wdata = $urandom;
    if (mcnt[s] > 0) begin mcnt[s]--; e = exp_desc(s, 1'b1, mdl[s][mcnt[s]]); end
    else e = exp_desc(s, 1'b0, '0);
    @(negedge clk);
    req_valid = 1'b0;
    chk({tag, " R4 rsp_valid"}, {63'd0, rsp_valid}, 64'd1);
    chk({tag, " R3/R5/R8 descriptor"}, rsp_data, e);
  endtask

  task automatic do_foreign(int s, logic wr);
    logic [2:0] rg;
    rg = 3'($urandom_range(0, 5));
    if (rg == 3'd5 && $urandom_range(0, 1) == 1) rg = 3'd7;
    req_valid = 1'b1; req_write = wr; req_addr = mk_addr(rg, s); req_wdata = {$urandom, $urandom};
    @(negedge clk);
    req_valid = 1'b0;
    chk("R1 foreign region gives no rsp", {63'd0, rsp_valid}, 64'd0);
  endtask

  task automatic do_cfg(int s, logic [2:0] v);
    cfg_we = 1'b1; cfg_stack = s[4:0]; cfg_size = v; msize[s] = v;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    tests_failed++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("[TB] %0d tests run, %0d failed", tests_run, tests_failed);
    $finish;
  end

  initial begin
    void'($urandom(32'd7351));
    for (int i = 0; i < NS; i++) begin mcnt[i] = 0; msize[i] = 3'd0; end
    movf = '0;
    rst_n = 1'b0; req_valid = 1'b0; req_write = 1'b0; req_addr = '0; req_wdata = '0;
    cfg_we = 1'b0; cfg_stack = '0; cfg_size = '0;
    repeat (3) @(negedge clk);
    chk("R10 rsp_valid in reset", {63'd0, rsp_valid}, 64'd0);
    chk("R10 ovf in reset", 64'(ovf_flags), 64'd0);
    rst_n = 1'b1;
    @(negedge clk);

    // R5 R6 R8: empty pop after reset, size 0
    do_pop(5, "R5 empty pop");

    // R3 R7 R8: LIFO order with size code, all-ones data outside the address field
    do_cfg(2, 3'd5);
    do_push(2, 64'hFFFF_FC00_0000_0000 | (64'h1 << 7) | 64'h7F, "R7 push a");
    do_push(2, {22'h3FFFFF, 35'h2_3456_789A, 7'h7F}, "R7 push b");
    do_push(2, 64'h0000_0123_4567_8980, "R3 push c");
    do_pop(2, "R3 pop c");
    do_pop(2, "R7 pop b");
    do_pop(2, "R7 pop a");
    do_pop(2, "R5 drained");

    // R2: neighbouring stacks stay separate
    do_push(30, 64'h0000_00AA_0000_0080, "R2 push 30");
    do_push(31, 64'h0000_00BB_0000_0100, "R2 push 31");
    do_pop(30, "R2 pop 30");
    do_pop(31, "R2 pop 31");

    // R9: fill stack 7 past depth
    for (int k = 0; k < DP + 2; k++) do_push(7, {$urandom, $urandom}, "R9 fill");
    chk("R9 only stack 7 flagged", 64'(ovf_flags), 64'(1) << 7);
    for (int k = 0; k < DP + 1; k++) do_pop(7, "R9 drain intact");

    // R1: foreign region push leaves stack 9 empty, foreign pop no response
    do_foreign(9, 1'b1);
    do_foreign(9, 1'b0);
    do_pop(9, "R1 stack untouched");

    // random phase
    for (int n = 0; n < 4000; n++) begin
      int r, s;
      r = $urandom_range(0, 99);
      case ($urandom_range(0, 4))
        0: s = 0; 1: s = 1; 2: s = 3; 3: s = 9; default: s = 31;
      endcase
      if (r < 50)      do_push(s, {$urandom, $urandom}, "rnd");
      else if (r < 88) do_pop(s, "rnd");
      else if (r < 94) do_cfg(s, 3'($urandom));
      else             do_foreign(s, r[0]);
    end
    chk("R9 final ovf", 64'(ovf_flags), 64'(movf));

    $display("[TB] %0d tests run, %0d failed", tests_run, tests_failed);
    $finish;
  end
endmodule